// File: doc/BRIEF.md
# CAS-Latency Read Data Aligner

This block sits on the read side of a synchronous DRAM controller, between the DQ input register and the host's read port. The command sequencer pulses `readIssue` in the cycle it issues a read and supplies the latency and burst setting that apply to that read. The aligner waits that many clocks, then samples `dqIn` once per clock for the length of the burst. Each sampled word goes to the host as `rdData` with `rdValid`. `rdLast` accompanies the final word of a fixed-length burst.

A burst can end early in two ways. The first is a stop pulse. The second is another read issued while a burst is still arriving or still waiting in the latency pipe. In both cases, words the device had already launched before the termination still arrive, and every later word is dropped. A full-page burst has no fixed end and runs until one of these terminations.

Latency and length are captured together with the read. The sequencer may change its mode inputs at any time without disturbing a burst that is already in flight.

Top module: `casReadAligner`

## Requirements
- R1: While `rstN` is low and after its release, `rdValid` and `rdLast` are 0 and `rdData` is 0 until a word is delivered.
- R2: A read sampled at clock edge k with `casLatency` = L (1, 2 or 3) captures `dqIn` at edges k+L, k+L+1, and so on. Each captured word appears on `rdData` with `rdValid` high in the cycle after its capture edge.
- R3: `burstCode` sets the fixed length: 3'b000 gives 1 word, 3'b001 gives 2, 3'b010 gives 4 and 3'b011 gives 8.
- R4: When `burstCode[2]` is 1 the burst is full page. Words keep arriving every clock until a termination, and `rdLast` stays 0 throughout.
- R5: `rdLast` is high together with the final word of a fixed-length burst that was not cut short, and at no other time.
- R6: A `stopIssue` sampled at edge s without a read drops every word whose capture edge is s+L or later, where L is the latency of the latest read. Words captured before that edge are still delivered.
- R7: A read at edge r while an earlier burst is pending or active cuts the old burst at edge r+min(Lold, Lnew). The new burst is then delivered with its own latency and length.
- R8: Changes on `casLatency` and `burstCode` in cycles without a read have no effect on a burst already issued.
- R9: `rdValid` returns to 0 in the cycle after the last word of a burst unless another burst continues at once.
- R10: A `stopIssue` sampled in the same cycle as a read, or before a read, does not shorten that read's burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| readIssue | input | 1 | Read command issued this cycle |
| stopIssue | input | 1 | Burst stop issued this cycle |
| casLatency | input | CL_W | Latency in clocks for this read (1 to MAX_CL) |
| burstCode | input | 3 | Burst length select for this read |
| dqIn | input | DATA_W | Registered data from the DRAM data bus |
| rdData | output | DATA_W | Word delivered to the host |
| rdValid | output | 1 | rdData holds a burst word this cycle |
| rdLast | output | 1 | Final word of a fixed-length burst |

## Verification
The bench uses the default build: a 16-bit data path and a latency pipe three stages deep. This depth makes all three latencies reachable, so reads with different latencies can overlap in the pipe. Reads are placed back to back with a long latency before a short one and a short one before a long one, which tests both the order in which events mature and the cancellation of stale events. Each word's value encodes its capture edge, so a word that arrives one clock early or late shows up as a data mismatch.

// File: rtl/casAlignPkg.sv
package casAlignPkg;

  // Remaining-word counter width: the longest fixed burst is 8 words.
  localparam int LEFT_W = 3;

  // Strobes from the control to the datapath for one clock.
  typedef struct packed {
    logic take;  // capture dqIn and present it as valid
    logic last;  // captured word ends a fixed-length burst
  } alignStrobes_t;

  // Words that follow the first one for a fixed burst length code.
  function automatic logic [LEFT_W-1:0] wordsAfterFirst(input logic [1:0] sel);
    return LEFT_W'((1 << sel) - 1);
  endfunction

endpackage

// File: rtl/casAlignCtrl.sv
module casAlignCtrl
  import casAlignPkg::*;
#(
  parameter int MAX_CL = 3,
  localparam int CL_W = $clog2(MAX_CL + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            readIssue,
  input  logic            stopIssue,
  input  logic [CL_W-1:0] casLatency,
  input  logic [2:0]      burstCode,
  output alignStrobes_t   strobes
);

  // Event pipes: an entry at index i matures i+1 edges after it is written.
  logic [MAX_CL-1:0] startPipe, stopPipe, fullPipe;
  logic [MAX_CL-1:0] startNext, stopNext, fullNext;
  logic [LEFT_W-1:0] leftPipe [MAX_CL];
  logic [LEFT_W-1:0] leftNext [MAX_CL];

  logic [CL_W-1:0]   curIdx, idxNext, newIdx;
  logic              active, activeNext;
  logic              fullMode, fullNow;
  logic [LEFT_W-1:0] wordsLeft, leftNow;

  function automatic logic [CL_W-1:0] clampIdx(input logic [CL_W-1:0] lat);
    if (lat == '0) return '0;
    else if (lat > CL_W'(MAX_CL)) return CL_W'(MAX_CL - 1);
    else return lat - 1'b1;
  endfunction

  // Event insertion and ageing
  always_comb begin
    newIdx    = clampIdx(casLatency);
    startNext = startPipe >> 1;
    stopNext  = stopPipe >> 1;
    fullNext  = fullPipe >> 1;
    for (int i = 0; i < MAX_CL - 1; i++) leftNext[i] = leftPipe[i+1];
    leftNext[MAX_CL-1] = '0;
    idxNext = curIdx;
    if (readIssue) begin
      // Anything maturing at or after the new start belongs to older reads.
      for (int i = 0; i < MAX_CL; i++) begin
        if (i >= int'(newIdx)) begin
          startNext[i] = 1'b0;
          stopNext[i]  = 1'b0;
        end
      end
      startNext[newIdx] = 1'b1;
      fullNext[newIdx]  = burstCode[2];
      leftNext[newIdx]  = wordsAfterFirst(burstCode[1:0]);
      if (curIdx < newIdx) stopNext[curIdx] = 1'b1;
      idxNext = newIdx;
    end else if (stopIssue) begin
      stopNext[curIdx] = 1'b1;
    end
  end

  // Burst tracking at the capture edge
  always_comb begin
    strobes    = '0;
    activeNext = active;
    fullNow    = fullMode;
    leftNow    = wordsLeft;
    if (startPipe[0]) begin
      strobes.take = 1'b1;
      strobes.last = !fullPipe[0] && (leftPipe[0] == '0);
      fullNow      = fullPipe[0];
      leftNow      = leftPipe[0];
      activeNext   = fullPipe[0] || (leftPipe[0] != '0);
    end else if (stopPipe[0]) begin
      activeNext = 1'b0;
    end else if (active) begin
      strobes.take = 1'b1;
      if (!fullMode) begin
        strobes.last = (wordsLeft == LEFT_W'(1));
        leftNow      = wordsLeft - 1'b1;
        activeNext   = (wordsLeft != LEFT_W'(1));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startPipe <= '0;
      stopPipe  <= '0;
      fullPipe  <= '0;
      for (int i = 0; i < MAX_CL; i++) leftPipe[i] <= '0;
      curIdx    <= '0;
      active    <= 1'b0;
      fullMode  <= 1'b0;
      wordsLeft <= '0;
    end else begin
      startPipe <= startNext;
      stopPipe  <= stopNext;
      fullPipe  <= fullNext;
      for (int i = 0; i < MAX_CL; i++) leftPipe[i] <= leftNext[i];
      curIdx    <= idxNext;
      active    <= activeNext;
      fullMode  <= fullNow;
      wordsLeft <= leftNow;
    end
  end

endmodule

// File: rtl/casAlignData.sv
module casAlignData
  import casAlignPkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  alignStrobes_t     strobes,
  input  logic [DATA_W-1:0] dqIn,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              rdLast
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
      rdLast  <= 1'b0;
    end else begin
      rdValid <= strobes.take;
      rdLast  <= strobes.last;
      if (strobes.take) rdData <= dqIn;
    end
  end

endmodule

// File: rtl/casReadAligner.sv
module casReadAligner
  import casAlignPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int MAX_CL = 3,
  localparam int CL_W = $clog2(MAX_CL + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              readIssue,
  input  logic              stopIssue,
  input  logic [CL_W-1:0]   casLatency,
  input  logic [2:0]        burstCode,
  input  logic [DATA_W-1:0] dqIn,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              rdLast
);

  alignStrobes_t strobes;

  casAlignCtrl #(.MAX_CL(MAX_CL)) ctrl_i (
    .clk(clk), .rstN(rstN), .readIssue(readIssue), .stopIssue(stopIssue),
    .casLatency(casLatency), .burstCode(burstCode), .strobes(strobes)
  );

  casAlignData #(.DATA_W(DATA_W)) data_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .dqIn(dqIn),
    .rdData(rdData), .rdValid(rdValid), .rdLast(rdLast)
  );

endmodule

// File: rtl/casReadAlignerChk.sv
module casReadAlignerChk #(
  parameter int MAX_CL = 3
) (
  input logic clk,
  input logic rstN,
  input logic readIssue,
  input logic stopIssue,
  input logic rdValid,
  input logic rdLast
);

  // R1: first edge out of reset shows an idle output
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!rdValid && !rdLast));

  // R5: the last flag only rides on a valid word
  assert_last_with_valid_R5: assert property (@(posedge clk) disable iff (!rstN)
    rdLast |-> rdValid);

  // The windows below are written out for a three-stage latency pipe.
  if (MAX_CL == 3) begin : g_cl3
    // R2: a burst only opens 1 to 3 clocks after a read
    assert_valid_follows_read_R2: assert property (@(posedge clk) disable iff (!rstN)
      $rose(rdValid) |-> ($past(readIssue, 2) || $past(readIssue, 3) || $past(readIssue, 4)));

    // R9: after a final word, valid drops unless a fresh burst starts
    assert_valid_drops_after_last_R9: assert property (@(posedge clk) disable iff (!rstN)
      rdLast |=> (!rdValid || $past(readIssue, 2) || $past(readIssue, 3) || $past(readIssue, 4)));

    // R6: a stop silences the output within the longest latency
    assert_stop_silences_R6: assert property (@(posedge clk) disable iff (!rstN)
      (stopIssue && !readIssue) |-> ##4
        (!rdValid || $past(readIssue, 1) || $past(readIssue, 2) || $past(readIssue, 3)));
  end

endmodule

bind casReadAligner casReadAlignerChk #(.MAX_CL(MAX_CL)) chk_i (
  .clk(clk), .rstN(rstN), .readIssue(readIssue), .stopIssue(stopIssue),
  .rdValid(rdValid), .rdLast(rdLast)
);

// File: tb/casReadAligner_tb_top.sv
`timescale 1ns/1ps
module casReadAligner_tb_top;

  localparam int DATA_W = 16;
  localparam int SPAN   = 20;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              readIssue = 1'b0;
  logic              stopIssue = 1'b0;
  logic [1:0]        casLatency = 2'd1;
  logic [2:0]        burstCode = 3'd0;
  logic [DATA_W-1:0] dqIn = '0;
  logic [DATA_W-1:0] rdData;
  logic              rdValid, rdLast;

  int nCompared = 0;
  int nMismatched = 0;
  bit summaryDone = 0;

  always #10 clk = ~clk;

  casReadAligner #(.DATA_W(DATA_W), .MAX_CL(3)) dut_i (
    .clk(clk), .rstN(rstN), .readIssue(readIssue), .stopIssue(stopIssue),
    .casLatency(casLatency), .burstCode(burstCode), .dqIn(dqIn),
    .rdData(rdData), .rdValid(rdValid), .rdLast(rdLast)
  );

  task automatic cmp(input string tag, input string what, input int got, input int exp);
    nCompared++;
    if (got != exp) begin
      nMismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, got, exp);
    end
  endtask

  function automatic int lenOf(input logic [2:0] code);
    return code[2] ? 100000 : (1 << code[1:0]);
  endfunction

  // Core scenario: read A at relative edge 0, optional stop, optional read B.
  task automatic runCase(input string tag, input int cl, input logic [2:0] bl,
                         input int stopAt, input bit preStop,
                         input int r2, input int cl2, input logic [2:0] bl2,
                         input logic [DATA_W-1:0] base);
    int lenA, lenB, cutA;
    lenA = lenOf(bl);
    lenB = lenOf(bl2);
    cutA = 1000000;
    if (stopAt >= 1) cutA = stopAt + cl;
    if (r2 > 0 && r2 + ((cl < cl2) ? cl : cl2) < cutA) cutA = r2 + ((cl < cl2) ? cl : cl2);
    if (preStop) begin
      @(negedge clk);
      stopIssue = 1'b1;
    end
    @(negedge clk);
    readIssue = 1'b1; casLatency = 2'(cl); burstCode = bl;
    stopIssue = (stopAt == 0); dqIn = base;
    for (int j = 1; j <= SPAN + 1; j++) begin
      @(negedge clk);
      begin : chk
        int e;
        bit vA, vB, eValid, eLast;
        e  = j - 1;
        vA = (e >= cl) && (e < cl + lenA) && (e < cutA);
        vB = (r2 > 0) && (e >= r2 + cl2) && (e < r2 + cl2 + lenB);
        eValid = vA || vB;
        eLast  = vB ? (!bl2[2] && e == r2 + cl2 + lenB - 1)
                    : (vA && !bl[2] && e == cl + lenA - 1);
        cmp(tag, $sformatf("rdValid edge %0d", e), int'(rdValid), int'(eValid));
        cmp(tag, $sformatf("rdLast edge %0d", e), int'(rdLast), int'(eLast));
        if (eValid) cmp(tag, $sformatf("rdData edge %0d", e), int'(rdData), int'(base) + e);
      end
      readIssue = (r2 > 0 && j == r2);
      stopIssue = (j == stopAt);
      if (r2 > 0 && j == r2) begin
        casLatency = 2'(cl2); burstCode = bl2;
      end else begin
        // R8: unrelated mode values on every other cycle
        casLatency = 2'((j % 3) + 1); burstCode = ~bl;
      end
      dqIn = base + DATA_W'(j);
    end
    readIssue = 1'b0; stopIssue = 1'b0;
  endtask

  task automatic testReset();
    cmp("R1", "rdValid after reset", int'(rdValid), 0);
    cmp("R1", "rdLast after reset", int'(rdLast), 0);
    cmp("R1", "rdData after reset", int'(rdData), 0);
  endtask

  task automatic testLatencies();
    runCase("R2/R8/R9", 1, 3'b010, -1, 0, 0, 1, 3'b000, 16'h1000);
    runCase("R2/R3", 2, 3'b000, -1, 0, 0, 1, 3'b000, 16'h2000);
    runCase("R2/R3", 3, 3'b001, -1, 0, 0, 1, 3'b000, 16'h3000);
  endtask

  task automatic testLongBurst();
    runCase("R3/R5", 3, 3'b011, -1, 0, 0, 1, 3'b000, 16'h4000);
  endtask

  task automatic testFullPage();
    runCase("R4/R6", 2, 3'b111, 6, 0, 0, 1, 3'b000, 16'h5000);
  endtask

  task automatic testStopFixed();
    runCase("R6/R5", 3, 3'b011, 2, 0, 0, 1, 3'b000, 16'h6000);
  endtask

  task automatic testReadCutsRead();
    runCase("R7", 3, 3'b011, -1, 0, 3, 1, 3'b001, 16'h7000);
    runCase("R7", 1, 3'b011, -1, 0, 4, 3, 3'b010, 16'h7800);
  endtask

  task automatic testStopBeforeRead();
    runCase("R10", 2, 3'b010, 0, 0, 0, 1, 3'b000, 16'h8000);
    runCase("R10", 1, 3'b010, -1, 1, 0, 1, 3'b000, 16'h9000);
  endtask

  initial begin
    #(20 * 200000);
    nMismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!summaryDone) begin
      summaryDone = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatched);
    end
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testLatencies();
    testLongBurst();
    testFullPage();
    testStopFixed();
    testReadCutsRead();
    testStopBeforeRead();
    if (!summaryDone) begin
      summaryDone = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatched);
    end
    $finish;
  end

endmodule